// File: doc/BRIEF.md
# Up/Down Timer Counter Core

This block is the counting heart of a general-purpose timer. A control word sets how a counter of parameterised width moves on each clock: steadily up, steadily down, or back and forth between 0 and a reload limit. Each wrap or turn of the counter is an overflow or an underflow. Either one, like a software update pulse or an update pulse from a slave controller, can cause an update event. At each update event the active reload limit is refreshed from the value the host last wrote, and an update interrupt request pulses.

The host writes the control word and the reload value through strobed ports and presents a compare value. The block returns the count, the live counting direction, the enable state, an update interrupt pulse, a compare pulse and a sampling tick whose period is picked by the control word. Direction is kept as a two-state machine. In edge-aligned operation, states `S_UP` and `S_DOWN` follow the direction bit. In center-aligned operation they are the live direction: the transition `S_UP -> S_DOWN` happens on an overflow turn and `S_DOWN -> S_UP` on an underflow turn. One-pulse operation stops the counter by clearing its own enable bit.

Control word bit positions: 0 enable, 1 update disable, 2 update source filter, 3 one-pulse, 4 direction (1 = down), 6:5 center mode, 7 reload buffering, 9:8 sampling division.

Top module: `udt_core`

## Requirements
- R1: After reset the count is 0, the enable, direction, update-interrupt and compare outputs are 0, and the sampling tick is high on every clock. While enable (bit 0) is 0 and no software update arrives, the count holds.
- R2: With center mode 00 and direction bit 0, the count steps up once per clock. When it is at or above the reload limit it wraps to 0, and update_irq is high in the same cycle the count shows 0.
- R3: With center mode 00 and direction bit 1, the count steps down once per clock. From 0 it wraps to the reload limit, and update_irq is high in that cycle. dir_o reads 1.
- R4: With a nonzero center mode, counting up from the value one below the limit moves to the limit and turns down (overflow, update_irq). Counting down from 1 moves to 0 and turns up (underflow, update_irq). dir_o shows the live direction. Writes to bit 4 are ignored during this mode, and on a return to mode 00 counting continues in the live direction.
- R5: With update disable (bit 1) set, wraps, software pulses and slave pulses raise no update_irq and do not refresh the active reload limit.
- R6: With the source filter (bit 2) at 0, a software update pulse or a slave update pulse raises update_irq one clock later. With it at 1, only a wrap or turn does.
- R7: With one-pulse (bit 3) set, the update event clears the enable bit in the same clock, and the count then holds.
- R8: With reload buffering (bit 7) set, a reload write takes effect at the next update event. With it clear, a reload write takes effect at once.
- R9: A software update pulse re-initialises the count in place of a step: to 0 when the current direction is up, and to the reload value when it is down.
- R10: compare_flag pulses in the cycle after the count steps onto the compare value. Center mode 01 qualifies only down steps, 10 only up steps, and 11 and 00 both.
- R11: Division field (bits 9:8) values 00, 01 and 10 give a sampling tick once every 1, 2 and 4 clocks. The reserved value 11 acts as 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 10 | Control word value |
| reload_wr | input | 1 | Reload value write strobe |
| reload_wdata | input | CW | Reload value |
| cmp_val | input | CW | Compare value |
| sw_upd | input | 1 | Software update-generate pulse |
| slv_upd | input | 1 | Slave-mode update pulse |
| count_o | output | CW | Counter value |
| update_irq | output | 1 | Update interrupt request pulse |
| compare_flag | output | 1 | Compare match pulse |
| dir_o | output | 1 | Live counting direction, 1 = down |
| enable_o | output | 1 | Enable state |
| smp_tick | output | 1 | Sampling tick |

## Verification
The bench targets the turn points of the center modes. A design with an off-by-one limit would turn at the limit itself or at 0, and the count sequence would shift. Writing the direction bit during center mode and then leaving that mode catches a design that lets the write through, because it would resume counting the wrong way. Buffered reload is checked by writing a smaller limit in mid-period: a design without the shadow wraps early. One-pulse, update disable and the source filter are each checked on the exact cycle of the event, where a wrong design either keeps counting or pulses update_irq.

// File: rtl/udt_pkg.sv
package udt_pkg;
    localparam int CTRL_W = 10;
    localparam int B_EN   = 0;
    localparam int B_UDIS = 1;
    localparam int B_URS  = 2;
    localparam int B_OPM  = 3;
    localparam int B_DIR  = 4;
    localparam int B_CMS  = 5;
    localparam int B_ARPE = 7;
    localparam int B_CKD  = 8;

    typedef enum logic {
        S_UP   = 1'b0,
        S_DOWN = 1'b1
    } dir_st_t;

    typedef enum logic [1:0] {
        CM_EDGE = 2'b00,
        CM_DN   = 2'b01,
        CM_UP   = 2'b10,
        CM_BOTH = 2'b11
    } cmode_t;
endpackage

// File: rtl/udt_ctrl.sv
module udt_ctrl
    import udt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              reload_wr,
    input  logic [CW-1:0]     reload_wdata,
    input  logic              upd_evt,
    input  logic              dir_hw,
    output logic              en_o,
    output logic              udis_o,
    output logic              urs_o,
    output logic              dir_o,
    output cmode_t            cms_o,
    output logic [CW-1:0]     arr_now,
    output logic [CW-1:0]     arr_load,
    output logic              smp_tick
);
    logic          en_q, udis_q, urs_q, opm_q, dir_q, arpe_q;
    cmode_t        cms_q;
    logic [1:0]    ckd_q;
    logic [CW-1:0] pre_q, shd_q;
    logic [1:0]    div_q, div_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            udis_q <= 1'b0;
            urs_q  <= 1'b0;
            opm_q  <= 1'b0;
            dir_q  <= 1'b0;
            arpe_q <= 1'b0;
            cms_q  <= CM_EDGE;
            ckd_q  <= 2'b00;
        end else begin
            if (ctrl_wr) begin
                en_q   <= ctrl_wdata[B_EN];
                udis_q <= ctrl_wdata[B_UDIS];
                urs_q  <= ctrl_wdata[B_URS];
                opm_q  <= ctrl_wdata[B_OPM];
                arpe_q <= ctrl_wdata[B_ARPE];
                cms_q  <= cmode_t'(ctrl_wdata[B_CMS +: 2]);
                ckd_q  <= ctrl_wdata[B_CKD +: 2];
            end else if (opm_q && upd_evt) begin
                en_q <= 1'b0;
            end
            // direction bit belongs to hardware while a center mode runs
            if (cms_q != CM_EDGE) begin
                dir_q <= dir_hw;
            end else if (ctrl_wr) begin
                dir_q <= ctrl_wdata[B_DIR];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            shd_q <= '0;
        end else begin
            if (reload_wr) begin
                pre_q <= reload_wdata;
            end
            if (reload_wr && !arpe_q) begin
                shd_q <= reload_wdata;
            end else if (upd_evt) begin
                shd_q <= pre_q;
            end
        end
    end

    always_comb begin
        unique case (ckd_q)
            2'b01:   div_mask = 2'b01;
            2'b10:   div_mask = 2'b11;
            default: div_mask = 2'b00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= 2'b00;
        end else begin
            div_q <= (div_q + 2'd1) & div_mask;
        end
    end

    assign smp_tick = (div_q == 2'b00);
    assign en_o     = en_q;
    assign udis_o   = udis_q;
    assign urs_o    = urs_q;
    assign dir_o    = dir_q;
    assign cms_o    = cms_q;
    assign arr_now  = shd_q;
    assign arr_load = pre_q;

    AST_OPM_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (opm_q && en_q && upd_evt && !ctrl_wr) |=> !en_q) else $error("opm"); // R7
    AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (arpe_q && !upd_evt) |=> $stable(shd_q)) else $error("shadow"); // R8
endmodule

// File: rtl/udt_engine.sv
module udt_engine
    import udt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          dir_bit,
    input  cmode_t        cms,
    input  logic          udis,
    input  logic          urs,
    input  logic [CW-1:0] arr_now,
    input  logic [CW-1:0] arr_load,
    input  logic          sw_upd,
    input  logic          slv_upd,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] cnt_nxt,
    output logic          step,
    output logic          step_down,
    output logic          dir_next,
    output logic          upd_evt,
    output logic          upd_irq
);
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    dir_st_t       state, state_d, state_run;
    logic [CW-1:0] cnt_q, cnt_run, cnt_d;
    logic          center, ovf, unf, wrap, irq_d;

    assign center    = (cms != CM_EDGE);
    assign step_down = center ? (state == S_DOWN) : dir_bit;
    assign step      = en && !sw_upd;

    always_comb begin
        ovf       = 1'b0;
        unf       = 1'b0;
        cnt_run   = cnt_q;
        state_run = state;
        if (center) begin
            unique case (state)
                S_UP: begin
                    if (arr_now == '0 || cnt_q >= arr_now - ONE) begin
                        cnt_run   = arr_now;
                        ovf       = 1'b1;
                        state_run = S_DOWN;
                    end else begin
                        cnt_run = cnt_q + ONE;
                    end
                end
                S_DOWN: begin
                    if (cnt_q <= ONE) begin
                        cnt_run   = '0;
                        unf       = 1'b1;
                        state_run = S_UP;
                    end else begin
                        cnt_run = cnt_q - ONE;
                    end
                end
            endcase
        end else begin
            state_run = dir_bit ? S_DOWN : S_UP;
            if (!dir_bit) begin
                if (cnt_q >= arr_now) begin
                    cnt_run = '0;
                    ovf     = 1'b1;
                end else begin
                    cnt_run = cnt_q + ONE;
                end
            end else begin
                if (cnt_q == '0) begin
                    cnt_run = arr_now;
                    unf     = 1'b1;
                end else begin
                    cnt_run = cnt_q - ONE;
                end
            end
        end
    end

    always_comb begin
        wrap = step && (ovf || unf);
        if (!center) begin
            state_d = dir_bit ? S_DOWN : S_UP;
        end else if (step) begin
            state_d = state_run;
        end else begin
            state_d = state;
        end
        if (sw_upd) begin
            cnt_d = step_down ? (udis ? arr_now : arr_load) : '0;
        end else if (step) begin
            cnt_d = cnt_run;
        end else begin
            cnt_d = cnt_q;
        end
        upd_evt = !udis && (wrap || sw_upd || slv_upd);
        irq_d   = upd_evt && (!urs || wrap);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_UP;
        end else begin
            state <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            upd_irq <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            upd_irq <= irq_d;
        end
    end

    assign cnt_o    = cnt_q;
    assign cnt_nxt  = cnt_run;
    assign dir_next = (state_d == S_DOWN);

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !sw_upd) |=> $stable(cnt_o)) else $error("hold"); // R1
    AST_UDIS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        udis |=> !upd_irq) else $error("udis"); // R5
    AST_URS_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        (urs && !wrap) |=> !upd_irq) else $error("urs"); // R6
endmodule

// File: rtl/udt_compare.sv
module udt_compare
    import udt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          step_down,
    input  logic [CW-1:0] cnt_nxt,
    input  logic [CW-1:0] cmp_val,
    input  cmode_t        cms,
    output logic          flag
);
    logic qual;

    always_comb begin
        unique case (cms)
            CM_DN:   qual = step_down;
            CM_UP:   qual = !step_down;
            default: qual = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else begin
            flag <= step && qual && (cnt_nxt == cmp_val);
        end
    end

    AST_CMP_DOWN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cms == CM_DN && step && !step_down) |=> !flag) else $error("cmp"); // R10
endmodule

// File: rtl/udt_core.sv
module udt_core
    import udt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              reload_wr,
    input  logic [CW-1:0]     reload_wdata,
    input  logic [CW-1:0]     cmp_val,
    input  logic              sw_upd,
    input  logic              slv_upd,
    output logic [CW-1:0]     count_o,
    output logic              update_irq,
    output logic              compare_flag,
    output logic              dir_o,
    output logic              enable_o,
    output logic              smp_tick
);
    logic          en, udis, urs, dir_bit, dir_next, upd_evt, step, step_down;
    cmode_t        cms;
    logic [CW-1:0] arr_now, arr_load, cnt_nxt;

    udt_ctrl #(.CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .reload_wr(reload_wr), .reload_wdata(reload_wdata),
        .upd_evt(upd_evt), .dir_hw(dir_next),
        .en_o(en), .udis_o(udis), .urs_o(urs), .dir_o(dir_bit), .cms_o(cms),
        .arr_now(arr_now), .arr_load(arr_load), .smp_tick(smp_tick)
    );

    udt_engine #(.CW(CW)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .en(en), .dir_bit(dir_bit), .cms(cms), .udis(udis), .urs(urs),
        .arr_now(arr_now), .arr_load(arr_load),
        .sw_upd(sw_upd), .slv_upd(slv_upd),
        .cnt_o(count_o), .cnt_nxt(cnt_nxt), .step(step), .step_down(step_down),
        .dir_next(dir_next), .upd_evt(upd_evt), .upd_irq(update_irq)
    );

    udt_compare #(.CW(CW)) u_cmp (
        .clk(clk), .rst_n(rst_n),
        .step(step), .step_down(step_down), .cnt_nxt(cnt_nxt),
        .cmp_val(cmp_val), .cms(cms), .flag(compare_flag)
    );

    assign dir_o    = step_down;
    assign enable_o = en;
endmodule

// File: tb/udt_core_test.sv
module udt_core_test;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctrl_wr = 1'b0;
    logic [9:0]    ctrl_wdata = '0;
    logic          reload_wr = 1'b0;
    logic [CW-1:0] reload_wdata = '0;
    logic [CW-1:0] cmp_val = '0;
    logic          sw_upd = 1'b0;
    logic          slv_upd = 1'b0;
    logic [CW-1:0] count_o;
    logic          update_irq, compare_flag, dir_o, enable_o, smp_tick;
    int            total = 0;
    int            bad = 0;
    bit            done = 1'b0;

    udt_core #(.CW(CW)) uut (.*);

    always #5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ctrl_wr = 1'b0; reload_wr = 1'b0;
        sw_upd = 1'b0; slv_upd = 1'b0; cmp_val = '0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic wr_ctrl(input logic [9:0] v);
        ctrl_wdata = v; ctrl_wr = 1'b1;
        tick();
        ctrl_wr = 1'b0;
    endtask

    task automatic wr_reload(input int v);
        reload_wdata = CW'(v); reload_wr = 1'b1;
        tick();
        reload_wr = 1'b0;
    endtask

    task automatic pulse_sw();
        sw_upd = 1'b1; tick(); sw_upd = 1'b0;
    endtask

    task automatic pulse_slv();
        slv_upd = 1'b1; tick(); slv_upd = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 count", int'(count_o), 0);
        chk("R1 enable", int'(enable_o), 0);
        chk("R1 dir", int'(dir_o), 0);
        chk("R1 irq", int'(update_irq), 0);
        chk("R1 cmp", int'(compare_flag), 0);
        chk("R1 tick", int'(smp_tick), 1);
        wr_reload(3);
        tick(); tick(); tick();
        chk("R1 hold", int'(count_o), 0);
    endtask

    task automatic t_up();
        do_reset();
        wr_reload(3);
        wr_ctrl(10'h001);
        tick(); chk("R2 c1", int'(count_o), 1);
        tick(); tick(); chk("R2 c3", int'(count_o), 3);
        chk("R2 noirq", int'(update_irq), 0);
        tick(); chk("R2 wrap", int'(count_o), 0);
        chk("R2 irq", int'(update_irq), 1);
        tick(); chk("R2 after", int'(count_o), 1);
    endtask

    task automatic t_down();
        do_reset();
        wr_reload(3);
        wr_ctrl(10'h011);
        tick(); chk("R3 wrap", int'(count_o), 3);
        chk("R3 irq", int'(update_irq), 1);
        chk("R3 dir", int'(dir_o), 1);
        tick(); chk("R3 c2", int'(count_o), 2);
        tick(); tick(); chk("R3 c0", int'(count_o), 0);
        tick(); chk("R3 wrap2", int'(count_o), 3);
    endtask

    task automatic t_center();
        do_reset();
        wr_reload(4);
        wr_ctrl(10'h021);
        tick(); chk("R4 c1", int'(count_o), 1);
        wr_ctrl(10'h031);
        chk("R4 dirwrite count", int'(count_o), 2);
        chk("R4 dirwrite ignored", int'(dir_o), 0);
        tick();
        tick(); chk("R4 top", int'(count_o), 4);
        chk("R4 top irq", int'(update_irq), 1);
        chk("R4 top dir", int'(dir_o), 1);
        tick(); chk("R4 c3", int'(count_o), 3);
        tick(); tick(); tick();
        chk("R4 bottom", int'(count_o), 0);
        chk("R4 bottom irq", int'(update_irq), 1);
        chk("R4 bottom dir", int'(dir_o), 0);
        tick(); chk("R4 rise", int'(count_o), 1);
        tick(); tick(); tick(); tick();
        chk("R4 falling", int'(count_o), 3);
        wr_ctrl(10'h001);
        chk("R4 exit count", int'(count_o), 2);
        chk("R4 exit dir", int'(dir_o), 1);
        tick(); chk("R4 keeps down", int'(count_o), 1);
    endtask

    task automatic t_udis();
        do_reset();
        wr_reload(3);
        wr_ctrl(10'h003);
        tick(); tick(); tick(); tick();
        chk("R5 wrapped", int'(count_o), 0);
        chk("R5 noirq", int'(update_irq), 0);
        pulse_sw();
        chk("R5 sw noirq", int'(update_irq), 0);
    endtask

    task automatic t_urs();
        do_reset();
        pulse_sw(); chk("R6 sw irq", int'(update_irq), 1);
        tick();     chk("R6 irq pulse", int'(update_irq), 0);
        pulse_slv(); chk("R6 slv irq", int'(update_irq), 1);
        wr_ctrl(10'h004);
        pulse_sw(); chk("R6 sw filtered", int'(update_irq), 0);
        pulse_slv(); chk("R6 slv filtered", int'(update_irq), 0);
        wr_reload(1);
        wr_ctrl(10'h005);
        tick(); tick();
        chk("R6 wrap count", int'(count_o), 0);
        chk("R6 wrap irq", int'(update_irq), 1);
    endtask

    task automatic t_opm();
        do_reset();
        wr_reload(2);
        wr_ctrl(10'h009);
        tick(); tick(); tick();
        chk("R7 wrap", int'(count_o), 0);
        chk("R7 irq", int'(update_irq), 1);
        chk("R7 en cleared", int'(enable_o), 0);
        tick(); tick();
        chk("R7 stopped", int'(count_o), 0);
    endtask

    task automatic t_preload();
        do_reset();
        wr_ctrl(10'h080);
        wr_reload(5);
        wr_ctrl(10'h081);
        tick(); chk("R8 old limit", int'(count_o), 0);
        chk("R8 old irq", int'(update_irq), 1);
        tick(); tick();
        wr_reload(2);
        chk("R8 buffered", int'(count_o), 3);
        tick(); tick(); tick();
        chk("R8 wrap5", int'(count_o), 0);
        chk("R8 wrap5 irq", int'(update_irq), 1);
        tick(); tick(); tick();
        chk("R8 wrap2", int'(count_o), 0);
    endtask

    task automatic t_ug();
        do_reset();
        wr_reload(6);
        wr_ctrl(10'h001);
        tick(); tick(); tick();
        pulse_sw();
        chk("R9 up reinit", int'(count_o), 0);
        chk("R9 up irq", int'(update_irq), 1);
        tick(); chk("R9 resume", int'(count_o), 1);
        wr_ctrl(10'h011);
        tick(); chk("R9 down", int'(count_o), 1);
        pulse_sw(); chk("R9 down reinit", int'(count_o), 6);
        tick(); chk("R9 down resume", int'(count_o), 5);
    endtask

    task automatic center_cmp(input logic [1:0] m, input int eu, input int ed, input string tag);
        do_reset();
        cmp_val = 16'd2;
        wr_reload(4);
        wr_ctrl({3'b000, m, 5'b00001});
        tick(); tick();
        chk({tag, " up match"}, int'(compare_flag), eu);
        tick(); tick(); tick(); tick();
        chk({tag, " down count"}, int'(count_o), 2);
        chk({tag, " down match"}, int'(compare_flag), ed);
    endtask

    task automatic t_cmp();
        do_reset();
        cmp_val = 16'd2;
        wr_reload(3);
        wr_ctrl(10'h001);
        tick(); chk("R10 edge no", int'(compare_flag), 0);
        tick(); chk("R10 edge hit", int'(compare_flag), 1);
        tick(); chk("R10 edge pulse", int'(compare_flag), 0);
        center_cmp(2'b01, 0, 1, "R10 m01");
        center_cmp(2'b10, 1, 0, "R10 m10");
        center_cmp(2'b11, 1, 1, "R10 m11");
    endtask

    task automatic t_ckd();
        do_reset();
        wr_ctrl(10'h100);
        chk("R11 d2 a", int'(smp_tick), 1);
        tick(); chk("R11 d2 b", int'(smp_tick), 0);
        tick(); chk("R11 d2 c", int'(smp_tick), 1);
        do_reset();
        wr_ctrl(10'h200);
        chk("R11 d4 a", int'(smp_tick), 1);
        tick(); tick(); tick();
        chk("R11 d4 b", int'(smp_tick), 0);
        tick(); chk("R11 d4 c", int'(smp_tick), 1);
        wr_ctrl(10'h300);
        tick(); chk("R11 reserved", int'(smp_tick), 1);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL ALL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_up();
        t_down();
        t_center();
        t_udis();
        t_urs();
        t_opm();
        t_preload();
        t_ug();
        t_cmp();
        t_ckd();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule